// File: doc/BRIEF.md
# Two-Dimensional DMA Address Stepper

This block produces the read and write addresses for a DMA channel that moves a block of data arranged as frames of elements. A start pulse captures a channel descriptor. The descriptor holds a start address, an access size, an addressing mode, an element offset and a frame offset for each side, and one element count per frame and one frame count shared by both sides. The source side and the destination side then advance on their own. The source moves forward on each accepted read strobe, and the destination moves forward on each accepted write strobe.

Each side chooses one of three modes. In fixed mode the address stays put. In sequential mode it grows by the access width after every element. In strided mode it moves by a signed element offset inside a frame, and by a signed frame offset after the last element of a frame. Because the two sides are configured separately, one side can walk memory linearly while the other gathers or scatters, or transposes rows into columns. A single counter holds the number of elements that are still to be read. Pulse and level flags report when a frame completes and when the whole block completes.

Top module: `dma_addr_gen`

## Requirements
- R1: One cycle after `start`, `src_addr` and `dst_addr` equal the configured start addresses, `remaining` equals element count × frame count, `busy` is 1 and `block_done` is 0.
- R2: A side in fixed mode (mode code 0) keeps its address unchanged while it steps.
- R3: A side in sequential mode (mode code 1) adds 1 to its address for each step when its size bit is 0 (8-bit), and adds 2 when its size bit is 1 (16-bit).
- R4: A side in strided mode (mode code 2) adds its sign-extended 16-bit element offset after each step that is not the last of a frame, and adds its sign-extended 16-bit frame offset after the last step of a frame. Offsets of zero and negative offsets are allowed.
- R5: All address arithmetic wraps modulo 2^32.
- R6: `remaining` falls by exactly one for each read strobe that is accepted while `busy`. It stays at 0 when further reads arrive, and it never rises except on `start`.
- R7: `frame_done` is high for the one cycle that follows each write that completes a frame, that is, every element-count writes.
- R8: After element count × frame count accepted writes, `block_done` goes to 1 and `busy` goes to 0. Both hold until the next `start`.
- R9: While `busy` is 0, read and write strobes leave `src_addr`, `dst_addr` and `remaining` unchanged.
- R10: A `start` with an element count or frame count of 0 gives `block_done`=1, `busy`=0 and `remaining`=0 in the next cycle.
- R11: `rd_size` and `wr_size` show the read and write size bits captured at `start` (0 = 8-bit, 1 = 16-bit).
- R12: Under reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Captures the descriptor and begins a block |
| cfg_src_addr | input | AW | Source start address |
| cfg_dst_addr | input | AW | Destination start address |
| cfg_src_mode | input | 2 | Source mode: 0 fixed, 1 sequential, 2 strided |
| cfg_dst_mode | input | 2 | Destination mode, same encoding as the source |
| cfg_rd_size | input | 1 | Read size: 0 = 8-bit, 1 = 16-bit |
| cfg_wr_size | input | 1 | Write size: 0 = 8-bit, 1 = 16-bit |
| cfg_elem_cnt | input | ECW | Elements per frame |
| cfg_frame_cnt | input | FCW | Frames per block |
| cfg_src_eoff | input | IW | Source signed element offset |
| cfg_src_foff | input | IW | Source signed frame offset |
| cfg_dst_eoff | input | IW | Destination signed element offset |
| cfg_dst_foff | input | IW | Destination signed frame offset |
| rd_strobe | input | 1 | One element read from the source |
| wr_strobe | input | 1 | One element written to the destination |
| src_addr | output | AW | Current source address |
| dst_addr | output | AW | Current destination address |
| rd_size | output | 1 | Captured read size |
| wr_size | output | 1 | Captured write size |
| remaining | output | ECW+FCW | Elements still to be read |
| frame_done | output | 1 | One-cycle pulse after a frame's last write |
| block_done | output | 1 | Block complete (level) |
| busy | output | 1 | Block in progress |

## Verification
The stepper is driven with several kinds of descriptor. A strided source with a negative frame offset is paired with a sequential 16-bit destination, which separates the element-offset step from the frame-offset step. The two zero-offset destination patterns (element 0 / frame 1 and element 1 / frame 0) give different address sequences only if the frame boundary is detected on the right element. A sequential source that starts just below 2^32 exposes any failure to wrap, and a frame length of one drives `frame_done` on back-to-back cycles. Reads that run ahead of writes, sparse strobe patterns, strobes after completion, zero counts and a restart in mid-block test that the read and write sides stay independent and that idle strobes are ignored.

// File: rtl/dma_ag_pkg.sv
package dma_ag_pkg;
  typedef enum logic [1:0] {
    MODE_FIXED = 2'd0,
    MODE_SEQ   = 2'd1,
    MODE_STRD  = 2'd2
  } mode_t;

  localparam int SIDES   = 2;
  localparam int SIDE_RD = 0;
  localparam int SIDE_WR = 1;
endpackage

// File: rtl/dma_ag_side.sv
module dma_ag_side
  import dma_ag_pkg::*;
#(
  parameter int AW  = 32,
  parameter int ECW = 16,
  parameter int IW  = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [AW-1:0]  base,
  input  mode_t          mode,
  input  logic           size16,
  input  logic [IW-1:0]  eoff,
  input  logic [IW-1:0]  foff,
  input  logic [ECW-1:0] elem_cnt,
  input  logic           step,
  output logic [AW-1:0]  addr,
  output logic           frame_end
);
  localparam int XW = AW - IW;

  mode_t          mode_q;
  logic           size_q;
  logic [IW-1:0]  eoff_q;
  logic [IW-1:0]  foff_q;
  logic [ECW-1:0] ecnt_q;
  logic [ECW-1:0] pos_q;
  logic           last_elem;
  logic [AW-1:0]  delta;

  assign last_elem = (pos_q == ECW'(1));
  assign frame_end = step && last_elem;

  always_comb begin
    case (mode_q)
      MODE_SEQ:  delta = size_q ? AW'(2) : AW'(1);
      MODE_STRD: delta = last_elem ? {{XW{foff_q[IW-1]}}, foff_q}
                                   : {{XW{eoff_q[IW-1]}}, eoff_q};
      default:   delta = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_FIXED;
      size_q <= 1'b0;
      eoff_q <= '0;
      foff_q <= '0;
      ecnt_q <= '0;
      pos_q  <= '0;
      addr   <= '0;
    end else if (load) begin
      mode_q <= mode;
      size_q <= size16;
      eoff_q <= eoff;
      foff_q <= foff;
      ecnt_q <= elem_cnt;
      pos_q  <= elem_cnt;
      addr   <= base;
    end else if (step) begin
      addr  <= addr + delta;
      pos_q <= last_elem ? ecnt_q : pos_q - ECW'(1);
    end
  end
endmodule

// File: rtl/dma_ag_count.sv
module dma_ag_count #(
  parameter int ECW = 16,
  parameter int FCW = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [ECW-1:0]     elem_cnt,
  input  logic [FCW-1:0]     frame_cnt,
  input  logic               rd_step,
  input  logic               wr_frame_end,
  output logic [ECW+FCW-1:0] remaining,
  output logic               busy,
  output logic               frame_done,
  output logic               block_done
);
  localparam int CW = ECW + FCW;

  logic [FCW-1:0] frames_q;
  logic           empty_cfg;

  assign empty_cfg = (elem_cnt == '0) || (frame_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      remaining  <= '0;
      frames_q   <= '0;
      busy       <= 1'b0;
      frame_done <= 1'b0;
      block_done <= 1'b0;
    end else if (load) begin
      remaining  <= empty_cfg ? '0 : CW'(elem_cnt) * CW'(frame_cnt);
      frames_q   <= frame_cnt;
      busy       <= !empty_cfg;
      block_done <= empty_cfg;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (busy) begin
        if (rd_step) remaining <= remaining - CW'(1);
        if (wr_frame_end) begin
          frame_done <= 1'b1;
          frames_q   <= frames_q - FCW'(1);
          if (frames_q == FCW'(1)) begin
            busy       <= 1'b0;
            block_done <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
  import dma_ag_pkg::*;
#(
  parameter int AW  = 32,
  parameter int ECW = 16,
  parameter int FCW = 16,
  parameter int IW  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [AW-1:0]      cfg_src_addr,
  input  logic [AW-1:0]      cfg_dst_addr,
  input  logic [1:0]         cfg_src_mode,
  input  logic [1:0]         cfg_dst_mode,
  input  logic               cfg_rd_size,
  input  logic               cfg_wr_size,
  input  logic [ECW-1:0]     cfg_elem_cnt,
  input  logic [FCW-1:0]     cfg_frame_cnt,
  input  logic [IW-1:0]      cfg_src_eoff,
  input  logic [IW-1:0]      cfg_src_foff,
  input  logic [IW-1:0]      cfg_dst_eoff,
  input  logic [IW-1:0]      cfg_dst_foff,
  input  logic               rd_strobe,
  input  logic               wr_strobe,
  output logic [AW-1:0]      src_addr,
  output logic [AW-1:0]      dst_addr,
  output logic               rd_size,
  output logic               wr_size,
  output logic [ECW+FCW-1:0] remaining,
  output logic               frame_done,
  output logic               block_done,
  output logic               busy
);
  logic [AW-1:0] side_base [SIDES];
  mode_t         side_mode [SIDES];
  logic          side_size [SIDES];
  logic [IW-1:0] side_eoff [SIDES];
  logic [IW-1:0] side_foff [SIDES];
  logic          side_step [SIDES];
  logic [AW-1:0] side_addr [SIDES];
  logic          side_fend [SIDES];
  logic          rd_go;
  logic          wr_go;

  assign rd_go = rd_strobe && busy && !start && (remaining != '0);
  assign wr_go = wr_strobe && busy && !start;

  assign side_base[SIDE_RD] = cfg_src_addr;
  assign side_mode[SIDE_RD] = mode_t'(cfg_src_mode);
  assign side_size[SIDE_RD] = cfg_rd_size;
  assign side_eoff[SIDE_RD] = cfg_src_eoff;
  assign side_foff[SIDE_RD] = cfg_src_foff;
  assign side_step[SIDE_RD] = rd_go;
  assign side_base[SIDE_WR] = cfg_dst_addr;
  assign side_mode[SIDE_WR] = mode_t'(cfg_dst_mode);
  assign side_size[SIDE_WR] = cfg_wr_size;
  assign side_eoff[SIDE_WR] = cfg_dst_eoff;
  assign side_foff[SIDE_WR] = cfg_dst_foff;
  assign side_step[SIDE_WR] = wr_go;

  for (genvar g = 0; g < SIDES; g++) begin : g_side
    dma_ag_side #(.AW(AW), .ECW(ECW), .IW(IW)) u_side (
      .clk      (clk),
      .rst      (rst),
      .load     (start),
      .base     (side_base[g]),
      .mode     (side_mode[g]),
      .size16   (side_size[g]),
      .eoff     (side_eoff[g]),
      .foff     (side_foff[g]),
      .elem_cnt (cfg_elem_cnt),
      .step     (side_step[g]),
      .addr     (side_addr[g]),
      .frame_end(side_fend[g])
    );
  end

  assign src_addr = side_addr[SIDE_RD];
  assign dst_addr = side_addr[SIDE_WR];

  dma_ag_count #(.ECW(ECW), .FCW(FCW)) u_count (
    .clk         (clk),
    .rst         (rst),
    .load        (start),
    .elem_cnt    (cfg_elem_cnt),
    .frame_cnt   (cfg_frame_cnt),
    .rd_step     (rd_go),
    .wr_frame_end(side_fend[SIDE_WR]),
    .remaining   (remaining),
    .busy        (busy),
    .frame_done  (frame_done),
    .block_done  (block_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_size <= 1'b0;
      wr_size <= 1'b0;
    end else if (start) begin
      rd_size <= cfg_rd_size;
      wr_size <= cfg_wr_size;
    end
  end
endmodule

// File: rtl/dma_addr_gen_chk.sv
module dma_addr_gen_chk #(
  parameter int AW  = 32,
  parameter int ECW = 16,
  parameter int FCW = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               start,
  input logic               rd_strobe,
  input logic               wr_strobe,
  input logic [ECW-1:0]     cfg_elem_cnt,
  input logic [FCW-1:0]     cfg_frame_cnt,
  input logic [AW-1:0]      src_addr,
  input logic [AW-1:0]      dst_addr,
  input logic [ECW+FCW-1:0] remaining,
  input logic               frame_done,
  input logic               block_done,
  input logic               busy
);
  assert_read_decrement_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && rd_strobe && !start && remaining != '0) |=> remaining == $past(remaining) - 1'b1);

  assert_no_rise_R6: assert property (@(posedge clk) disable iff (rst)
    !start |=> remaining <= $past(remaining));

  assert_frame_after_write_R7: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> $past(wr_strobe));

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
    block_done |-> !busy);

  assert_idle_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(src_addr) && $stable(dst_addr) && $stable(remaining)));

  assert_empty_cfg_R10: assert property (@(posedge clk) disable iff (rst)
    (start && (cfg_elem_cnt == '0 || cfg_frame_cnt == '0)) |=> (block_done && !busy && remaining == '0));
endmodule

bind dma_addr_gen dma_addr_gen_chk #(.AW(AW), .ECW(ECW), .FCW(FCW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .start        (start),
  .rd_strobe    (rd_strobe),
  .wr_strobe    (wr_strobe),
  .cfg_elem_cnt (cfg_elem_cnt),
  .cfg_frame_cnt(cfg_frame_cnt),
  .src_addr     (src_addr),
  .dst_addr     (dst_addr),
  .remaining    (remaining),
  .frame_done   (frame_done),
  .block_done   (block_done),
  .busy         (busy)
);

// File: tb/sim_dma_addr_gen.sv
`timescale 1ns/1ps
module sim_dma_addr_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] cfg_src_addr = '0, cfg_dst_addr = '0;
  logic [1:0]  cfg_src_mode = '0, cfg_dst_mode = '0;
  logic        cfg_rd_size = 1'b0, cfg_wr_size = 1'b0;
  logic [15:0] cfg_elem_cnt = '0, cfg_frame_cnt = '0;
  logic [15:0] cfg_src_eoff = '0, cfg_src_foff = '0, cfg_dst_eoff = '0, cfg_dst_foff = '0;
  logic        rd_strobe = 1'b0, wr_strobe = 1'b0;
  logic [31:0] src_addr, dst_addr, remaining;
  logic        rd_size, wr_size, frame_done, block_done, busy;

  int errs = 0;
  int checks = 0;

  // reference model state
  int          m_e = 0, m_f = 0, m_nr = 0, m_nw = 0;
  logic        m_busy = 0, m_done = 0, m_fd = 0, m_rs = 0, m_ws = 0;
  logic [31:0] m_sb = 0, m_db = 0;
  logic [1:0]  m_sm = 0, m_dm = 0;
  int          m_se = 0, m_sf = 0, m_de = 0, m_df = 0;

  always #10 clk = ~clk;

  dma_addr_gen u0 (
    .clk(clk), .rst(rst), .start(start),
    .cfg_src_addr(cfg_src_addr), .cfg_dst_addr(cfg_dst_addr),
    .cfg_src_mode(cfg_src_mode), .cfg_dst_mode(cfg_dst_mode),
    .cfg_rd_size(cfg_rd_size), .cfg_wr_size(cfg_wr_size),
    .cfg_elem_cnt(cfg_elem_cnt), .cfg_frame_cnt(cfg_frame_cnt),
    .cfg_src_eoff(cfg_src_eoff), .cfg_src_foff(cfg_src_foff),
    .cfg_dst_eoff(cfg_dst_eoff), .cfg_dst_foff(cfg_dst_foff),
    .rd_strobe(rd_strobe), .wr_strobe(wr_strobe),
    .src_addr(src_addr), .dst_addr(dst_addr),
    .rd_size(rd_size), .wr_size(wr_size), .remaining(remaining),
    .frame_done(frame_done), .block_done(block_done), .busy(busy)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_addr(input logic [31:0] base, input logic [1:0] m,
                                           input logic sz, input int ei, input int fi, input int n);
    if (m == 2'd1) return base + 32'(n * (sz ? 2 : 1));
    if (m == 2'd2 && m_e > 0)
      return base + 32'((n / m_e) * ((m_e - 1) * ei + fi) + (n % m_e) * ei);
    return base;
  endfunction

  function automatic string mtag(input logic [1:0] m);
    return (m == 2'd1) ? "R3" : (m == 2'd2) ? "R4" : "R2";
  endfunction

  task automatic compare_all();
    chk({mtag(m_sm), " src_addr"}, src_addr, exp_addr(m_sb, m_sm, m_rs, m_se, m_sf, m_nr));
    chk({mtag(m_dm), " dst_addr"}, dst_addr, exp_addr(m_db, m_dm, m_ws, m_de, m_df, m_nw));
    chk("R6 remaining", remaining, 32'(m_e * m_f - m_nr));
    chk("R7 frame_done", {31'd0, frame_done}, {31'd0, m_fd});
    chk("R8 block_done", {31'd0, block_done}, {31'd0, m_done});
    chk("R8 busy", {31'd0, busy}, {31'd0, m_busy});
    chk("R11 sizes", {30'd0, rd_size, wr_size}, {30'd0, m_rs, m_ws});
  endtask

  // one clock: drive at negedge, update model at posedge, compare at next negedge
  task automatic cyc(input bit st, input bit r, input bit w);
    start = st; rd_strobe = r; wr_strobe = w;
    @(posedge clk);
    if (st) begin
      m_e = int'(cfg_elem_cnt); m_f = int'(cfg_frame_cnt);
      m_nr = 0; m_nw = 0; m_fd = 0;
      m_sb = cfg_src_addr; m_db = cfg_dst_addr;
      m_sm = cfg_src_mode; m_dm = cfg_dst_mode;
      m_rs = cfg_rd_size;  m_ws = cfg_wr_size;
      m_se = int'($signed(cfg_src_eoff)); m_sf = int'($signed(cfg_src_foff));
      m_de = int'($signed(cfg_dst_eoff)); m_df = int'($signed(cfg_dst_foff));
      m_busy = (m_e != 0 && m_f != 0);
      m_done = !m_busy;
      if (!m_busy) begin m_e = 0; m_f = 0; end
    end else begin
      m_fd = 0;
      if (m_busy) begin
        if (r && m_nr < m_e * m_f) m_nr++;
        if (w) begin
          m_nw++;
          if (m_nw % m_e == 0) m_fd = 1;
          if (m_nw == m_e * m_f) begin m_busy = 0; m_done = 1; end
        end
      end
    end
    @(negedge clk);
    start = 0; rd_strobe = 0; wr_strobe = 0;
    compare_all();
  endtask

  task automatic setup(input logic [31:0] sa, input logic [31:0] da, input logic [1:0] sm,
                       input logic [1:0] dm, input logic rs, input logic ws, input int e,
                       input int f, input int se, input int sf, input int de, input int df);
    cfg_src_addr = sa; cfg_dst_addr = da; cfg_src_mode = sm; cfg_dst_mode = dm;
    cfg_rd_size = rs; cfg_wr_size = ws; cfg_elem_cnt = 16'(e); cfg_frame_cnt = 16'(f);
    cfg_src_eoff = 16'(se); cfg_src_foff = 16'(sf); cfg_dst_eoff = 16'(de); cfg_dst_foff = 16'(df);
  endtask

  initial begin
    #(200000 * 20);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [31:0] hs, hd, hr;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12: reset state
    chk("R12 reset outputs", src_addr | dst_addr | remaining, 32'd0);
    chk("R12 reset flags", {27'd0, rd_size, wr_size, frame_done, block_done, busy}, 32'd0);
    rst = 0;

    // strided source with negative frame offset, sequential 16-bit destination
    setup(32'h1000, 32'h8000, 2'd2, 2'd1, 1'b0, 1'b1, 3, 2, 4, -8, 0, 0);
    cyc(1, 0, 0);
    chk("R1 start src", src_addr, 32'h1000);
    chk("R1 start dst", dst_addr, 32'h8000);
    chk("R1 start remaining", remaining, 32'd6);
    for (int i = 0; i < 6; i++) cyc(0, 1, 1);
    chk("R8 block complete", {31'd0, block_done}, 32'd1);
    hs = src_addr; hd = dst_addr; hr = remaining;
    for (int i = 0; i < 3; i++) cyc(0, 1, 1);
    chk("R9 src frozen", src_addr, hs);
    chk("R9 dst frozen", dst_addr, hd);
    chk("R9 remaining frozen", remaining, hr);

    // zero offsets: element 0 / frame 1, reads run ahead of writes
    setup(32'h40, 32'h200, 2'd1, 2'd2, 1'b0, 1'b0, 4, 2, 0, 0, 0, 1);
    cyc(1, 0, 0);
    for (int i = 0; i < 10; i++) cyc(0, 1, 0);
    chk("R6 holds at zero", remaining, 32'd0);
    for (int i = 0; i < 8; i++) cyc(0, 0, 1);

    // zero offsets: element 1 / frame 0, sparse strobes
    setup(32'h40, 32'h200, 2'd0, 2'd2, 1'b1, 1'b1, 4, 2, 0, 0, 1, 0);
    cyc(1, 0, 0);
    for (int i = 0; i < 20; i++) cyc(0, (i % 2) == 0, (i % 3) != 0);

    // wrap at 2^32, fixed destination
    setup(32'hFFFF_FFFE, 32'h0000_0010, 2'd1, 2'd0, 1'b1, 1'b0, 2, 2, 0, 0, 0, 0);
    cyc(1, 0, 0);
    cyc(0, 1, 1);
    chk("R5 wrap to zero", src_addr, 32'h0000_0000);
    for (int i = 0; i < 3; i++) cyc(0, 1, 1);

    // strided source wrapping downward
    setup(32'h0000_0004, 32'h0, 2'd2, 2'd1, 1'b0, 1'b0, 2, 2, -4, -4, 0, 0);
    cyc(1, 0, 0);
    for (int i = 0; i < 4; i++) cyc(0, 1, 1);
    chk("R5 wrap below zero", src_addr, 32'hFFFF_FFF4);

    // one element per frame: back-to-back frame pulses
    setup(32'h100, 32'h300, 2'd2, 2'd2, 1'b0, 1'b1, 1, 3, 7, 16, 5, -2);
    cyc(1, 0, 0);
    cyc(0, 1, 1);
    cyc(0, 1, 1);
    chk("R7 consecutive frame_done", {31'd0, frame_done}, 32'd1);
    cyc(0, 1, 1);

    // zero counts
    setup(32'h10, 32'h20, 2'd1, 2'd1, 1'b0, 1'b0, 0, 5, 0, 0, 0, 0);
    cyc(1, 0, 0);
    chk("R10 zero elem count", {30'd0, block_done, busy}, 32'd2);
    cyc(0, 1, 1);
    setup(32'h10, 32'h20, 2'd1, 2'd1, 1'b0, 1'b0, 3, 0, 0, 0, 0, 0);
    cyc(1, 0, 0);
    chk("R10 zero frame count", remaining, 32'd0);

    // restart in mid-block
    setup(32'h500, 32'h600, 2'd1, 2'd2, 1'b1, 1'b0, 3, 3, 0, 0, 2, 10);
    cyc(1, 0, 0);
    for (int i = 0; i < 4; i++) cyc(0, 1, 1);
    setup(32'h700, 32'h900, 2'd2, 2'd1, 1'b0, 1'b1, 2, 3, 3, -1, 0, 0);
    cyc(1, 1, 1);
    chk("R1 restart src", src_addr, 32'h700);
    chk("R1 restart remaining", remaining, 32'd6);
    for (int i = 0; i < 8; i++) cyc(0, 1, (i % 4) != 3);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule